// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This controller gathers a set of level-sensitive interrupt sources and presents them to a processor on two request lines: a fast-request line and a normal-request line. Each source can be routed to either line, or to both, by its enable bit in the matching level's bank. Each level has a status view, which is the source level ANDed with the enable. Software reads this view to find which sources need service. No source has priority over another within a level. A priority order, if one is needed, is left to the service routine.

Software programs the block over a plain word-addressed register bus with combinational read data. Enable bits are set by writing ones to a set register and cleared by writing ones to a separate disable register, so no read-modify-write sequence is needed. A software-request register can force either request line high, whatever the enables hold. Its bits stay set until software writes them back to zero.

Register map (word address; bit n of a source register refers to source n):

| Addr | Name | Access |
|---|---|---|
| 0 | normal status | read only |
| 1 | normal raw | read only |
| 2 | normal enable | read; write 1 sets |
| 3 | normal disable | write 1 clears enable; reads 0 |
| 4 | fast status | read only |
| 5 | fast raw | read only |
| 6 | fast enable | read; write 1 sets |
| 7 | fast disable | write 1 clears enable; reads 0 |
| 8 | software request | read/write; bit 0 = normal line, bit 1 = fast line |

Top module: `icu_top`

## Requirements
- R1: After reset, every enable bit and both software-request bits read 0. Both request lines are low even while every source is high.
- R2: The raw registers (address 1 and address 5) read the current source levels, whether or not any source is enabled.
- R3: A write to an enable register (address 2 or 6) sets each enable bit written as 1. Enable bits written as 0 keep their value.
- R4: A write to a disable register (address 3 or 7) clears each enable bit written as 1 and leaves the other bits unchanged. A disable register reads as 0.
- R5: Each status register (address 0 or 4) reads the source levels ANDed with the enable bits of its own level.
- R6: Each request line is high exactly when its level's status is non-zero or its software-request bit is set. The line follows the sources in the same cycle and follows a register write from the next cycle on.
- R7: A source enabled at both levels shows in both status registers and drives both request lines high.
- R8: Software-request bit 0 forces the normal line and bit 1 forces the fast line, without any enable. Each bit holds its value until a write to address 8 changes it.
- R9: The enable bits of one level are independent of writes to the other level's registers.
- R10: Writes to read-only addresses leave all state unchanged. Writes made while the bus select is low leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Level-sensitive interrupt sources, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data, valid in the same cycle as bus_sel |
| irq_o | output | 1 | Normal-level request, active high |
| fiq_o | output | 1 | Fast-level request, active high |

## Verification
The bench builds the block with NSRC set to 12, a width that is not a power of two. This checks that the register bus width and the per-source masks follow the parameter, and that no part of the design assumes 32 bits. With 12 sources the bench can write all-ones patterns to the disable registers. It can also place sources at both ends of the vector and give one source both levels at once. The software-request bits then sit in the low bits of a 12-bit word, with the upper bits reading 0.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int NUM_LVL = 2;
  localparam int LVL_IRQ = 0;
  localparam int LVL_FIQ = 1;
  localparam int REG_AW  = 4;
  localparam int LVL_STRIDE = 4;

  // offsets inside one level's register group
  localparam logic [REG_AW-1:0] OFS_STAT = 4'd0;
  localparam logic [REG_AW-1:0] OFS_RAW  = 4'd1;
  localparam logic [REG_AW-1:0] OFS_EN   = 4'd2;
  localparam logic [REG_AW-1:0] OFS_DIS  = 4'd3;

  typedef enum logic [REG_AW-1:0] {
    A_IRQ_STAT = 4'd0,
    A_IRQ_RAW  = 4'd1,
    A_IRQ_EN   = 4'd2,
    A_IRQ_DIS  = 4'd3,
    A_FIQ_STAT = 4'd4,
    A_FIQ_RAW  = 4'd5,
    A_FIQ_EN   = 4'd6,
    A_FIQ_DIS  = 4'd7,
    A_SWREQ    = 4'd8
  } icu_addr_e;

  function automatic logic [REG_AW-1:0] lvl_addr(input int lvl,
                                                 input logic [REG_AW-1:0] ofs);
    return REG_AW'(lvl * LVL_STRIDE) + ofs;
  endfunction
endpackage

// File: rtl/icu_level.sv
module icu_level #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [NSRC-1:0] wdata,
  input  logic            force_i,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] stat_o,
  output logic            req_o
);
  logic [NSRC-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (set_we) en_d = en_d | wdata;
    if (clr_we) en_d = en_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign stat_o = src_i & en_q;
  assign req_o  = (|stat_o) | force_i;
endmodule

// File: rtl/icu_swreq.sv
module icu_swreq #(
  parameter int NLVL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [NLVL-1:0] wdata,
  output logic [NLVL-1:0] req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  req_q <= '0;
    else if (we) req_q <= wdata;
  end
endmodule

// File: rtl/icu_regif.sv
module icu_regif
  import icu_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [NSRC-1:0]   src_i,
  input  logic [NSRC-1:0]   lvl_en   [NUM_LVL],
  input  logic [NSRC-1:0]   lvl_stat [NUM_LVL],
  input  logic [NUM_LVL-1:0] swreq_q,
  output logic [NUM_LVL-1:0] set_we,
  output logic [NUM_LVL-1:0] clr_we,
  output logic              swreq_we,
  output logic [NSRC-1:0]   bus_rdata
);
  logic wr;
  assign wr = bus_sel && bus_we;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_dec
    assign set_we[l] = wr && (bus_addr == lvl_addr(l, OFS_EN));
    assign clr_we[l] = wr && (bus_addr == lvl_addr(l, OFS_DIS));
  end

  assign swreq_we = wr && (bus_addr == A_SWREQ);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      for (int l = 0; l < NUM_LVL; l++) begin
        if (bus_addr == lvl_addr(l, OFS_STAT)) bus_rdata = lvl_stat[l];
        if (bus_addr == lvl_addr(l, OFS_RAW))  bus_rdata = src_i;
        if (bus_addr == lvl_addr(l, OFS_EN))   bus_rdata = lvl_en[l];
      end
      if (bus_addr == A_SWREQ) bus_rdata[NUM_LVL-1:0] = swreq_q;
    end
  end
endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [NSRC-1:0]    lvl_en   [NUM_LVL];
  logic [NSRC-1:0]    lvl_stat [NUM_LVL];
  logic [NUM_LVL-1:0] lvl_req;
  logic [NUM_LVL-1:0] set_we;
  logic [NUM_LVL-1:0] clr_we;
  logic [NUM_LVL-1:0] swreq_q;
  logic               swreq_we;

  icu_regif #(.NSRC(NSRC)) u_regif (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .src_i    (src_i),
    .lvl_en   (lvl_en),
    .lvl_stat (lvl_stat),
    .swreq_q  (swreq_q),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .swreq_we (swreq_we),
    .bus_rdata(bus_rdata)
  );

  icu_swreq #(.NLVL(NUM_LVL)) u_swreq (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (swreq_we),
    .wdata(bus_wdata[NUM_LVL-1:0]),
    .req_q(swreq_q)
  );

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    icu_level #(.NSRC(NSRC)) u_level (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .set_we (set_we[l]),
      .clr_we (clr_we[l]),
      .wdata  (bus_wdata),
      .force_i(swreq_q[l]),
      .en_q   (lvl_en[l]),
      .stat_o (lvl_stat[l]),
      .req_o  (lvl_req[l])
    );
  end

  assign irq_o = lvl_req[LVL_IRQ];
  assign fiq_o = lvl_req[LVL_FIQ];
endmodule

// File: rtl/icu_chk.sv
module icu_chk
  import icu_pkg::*;
#(
  parameter int NSRC = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_i,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic [NSRC-1:0]   bus_wdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NSRC-1:0]   irq_en,
  input logic [NSRC-1:0]   fiq_en,
  input logic [NUM_LVL-1:0] swreq
);
  logic wr;
  assign wr = bus_sel && bus_we;

  a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_IRQ_EN) |=> ((irq_en & $past(bus_wdata)) == $past(bus_wdata)));

  a_r4_clear_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_FIQ_DIS) |=> ((fiq_en & $past(bus_wdata)) == '0));

  a_r4_clear_spares: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_IRQ_DIS) |=> ((irq_en | $past(bus_wdata)) == ($past(irq_en) | $past(bus_wdata))));

  a_r9_fiq_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (bus_addr == A_FIQ_EN || bus_addr == A_FIQ_DIS)) |=> $stable(fiq_en));

  a_r8_swreq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == A_SWREQ) |=> $stable(swreq));

  a_r8_swreq_forces: assert property (@(posedge clk) disable iff (!rst_n)
    swreq[LVL_FIQ] |-> fiq_o);

  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i & irq_en) == '0 && !swreq[LVL_IRQ]) |-> !irq_o);

  a_r7_both_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_i & irq_en & fiq_en)) |-> (irq_o && fiq_o));
endmodule

bind icu_top icu_chk #(.NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_i    (src_i),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .irq_en   (lvl_en[0]),
  .fiq_en   (lvl_en[1]),
  .swreq    (swreq_q)
);

// File: tb/icu_top_tb.sv
module icu_top_tb;
  localparam int N = 12;
  localparam logic [N-1:0] ALL = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_i = '0;
  logic         bus_sel = 1'b0;
  logic         bus_we = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  icu_top #(.NSRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d, input logic sel = 1'b1);
    @(negedge clk);
    bus_sel = sel; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [N-1:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    check(tag, 32'(bus_rdata), 32'(exp));
    bus_sel = 1'b0;
  endtask

  task automatic lines_check(input string tag, input logic ei, input logic ef);
    @(negedge clk);
    check({tag, " irq"}, 32'(irq_o), 32'(ei));
    check({tag, " fiq"}, 32'(fiq_o), 32'(ef));
  endtask

  task automatic t_reset;
    src_i = ALL;
    lines_check("R1 lines after reset", 1'b0, 1'b0);
    rd_check("R1 irq enable", 4'd2, '0);
    rd_check("R1 fiq enable", 4'd6, '0);
    rd_check("R1 swreq", 4'd8, '0);
  endtask

  task automatic t_raw;
    src_i = 12'hA5C;
    rd_check("R2 irq raw", 4'd1, 12'hA5C);
    rd_check("R2 fiq raw", 4'd5, 12'hA5C);
    src_i = 12'h803;
    rd_check("R2 raw follows", 4'd1, 12'h803);
    lines_check("R6 no enable no request", 1'b0, 1'b0);
  endtask

  task automatic t_enable;
    src_i = '0;
    wr(4'd2, 12'h00F);
    rd_check("R3 first set", 4'd2, 12'h00F);
    wr(4'd2, 12'h030);
    rd_check("R3 zeros keep", 4'd2, 12'h03F);
    rd_check("R9 fiq enable untouched", 4'd6, '0);
    src_i = 12'h0A5;
    rd_check("R5 irq status", 4'd0, 12'h025);
    rd_check("R5 fiq status", 4'd4, '0);
    lines_check("R6 irq from status", 1'b1, 1'b0);
  endtask

  task automatic t_disable;
    wr(4'd3, 12'h005);
    rd_check("R4 selective clear", 4'd2, 12'h03A);
    rd_check("R4 disable reads zero", 4'd3, '0);
    src_i = 12'h0C5;
    rd_check("R5 status after clear", 4'd0, '0);
    lines_check("R6 request drops", 1'b0, 1'b0);
  endtask

  task automatic t_both;
    wr(4'd6, 12'h800);
    src_i = 12'h800;
    lines_check("R6 fiq only", 1'b0, 1'b1);
    rd_check("R9 irq enable untouched", 4'd2, 12'h03A);
    wr(4'd2, 12'h800);
    rd_check("R7 irq status", 4'd0, 12'h800);
    rd_check("R7 fiq status", 4'd4, 12'h800);
    lines_check("R7 both lines", 1'b1, 1'b1);
  endtask

  task automatic t_swreq;
    wr(4'd3, ALL);
    wr(4'd7, ALL);
    src_i = ALL;
    lines_check("R4 all cleared", 1'b0, 1'b0);
    wr(4'd8, 12'h001);
    lines_check("R8 force irq", 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    lines_check("R8 force holds", 1'b1, 1'b0);
    rd_check("R8 swreq readback", 4'd8, 12'h001);
    wr(4'd8, 12'h002);
    lines_check("R8 force fiq", 1'b0, 1'b1);
    wr(4'd8, 12'h000);
    lines_check("R8 released", 1'b0, 1'b0);
  endtask

  task automatic t_readonly;
    wr(4'd0, ALL);
    wr(4'd1, ALL);
    wr(4'd4, ALL);
    rd_check("R10 irq enable after ro write", 4'd2, '0);
    rd_check("R10 fiq enable after ro write", 4'd6, '0);
    wr(4'd2, ALL, 1'b0);
    wr(4'd8, 12'h003, 1'b0);
    rd_check("R10 unselected enable write", 4'd2, '0);
    lines_check("R10 unselected swreq write", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_raw();
    t_enable();
    t_disable();
    t_both();
    t_swreq();
    t_readonly();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule